// File: doc/BRIEF.md
# Block-Transfer DMA Bus Master

This engine moves one fixed-size card data block between system memory and the card data path. It uses a 32-bit Wishbone master port. Software writes a single start address before it issues a data-carrying command. The same address is the memory source when the command sends data to the card, and the memory destination when the command fetches data from it. This works because the card link carries data in only one direction at a time.

The engine waits for the command stage to report its end. If that command succeeded and carries a data payload, the engine latches the address and the direction.

- **To-card direction:** it reads memory words with classic single Wishbone cycles and hands each word to the transmit FIFO.
- **From-card direction:** it takes words from the receive FIFO and writes them to consecutive memory words.

A one-cycle done pulse marks the end of the block. A one-cycle FIFO-fault pulse marks an aborted transfer. A transfer aborts when the bus was too slow, so that the transmit FIFO drained early or the receive FIFO filled up.

Top module: `blk_dma_master`

## Requirements
- R1: A transfer starts only in a cycle where `cmd_end_i`, `cmd_ok_i` and `cmd_data_i` are all high. A command end with `cmd_ok_i` low, or with `cmd_data_i` low, starts no bus cycle, no push and no pop.
- R2: With `dir_wr_i`=1 at start, the engine reads memory at the latched address and at each following word. It pushes the words into the transmit FIFO in address order, with `tx_data_o` valid while `tx_push_o` is high.
- R3: With `dir_wr_i`=0 at start, the engine pops receive words (`rx_data_i` is the FIFO head while `rx_empty_i` is low). It writes them in pop order to the latched address and the following words, with `m_we_o`=1.
- R4: `m_adr_o` advances by 4 after each acknowledged word. While `m_cyc_o` is high, `m_sel_o`=4'b1111, `m_cti_o`=3'b000 and `m_bte_o`=2'b00.
- R5: Once raised, `m_cyc_o` and `m_stb_o` stay high until `m_ack_i` is seen, unless the transfer aborts.
- R6: In the cycle after an acknowledge, `m_cyc_o` is low. Each acknowledge completes exactly one word.
- R7: `done_o` pulses for one cycle, once per block, after BLOCK_WORDS words have been transferred.
- R8: In the to-card direction, `tx_empty_i` high after at least one word has been pushed and before the last word is pushed raises `fifo_err_o`.
- R9: In the from-card direction, `rx_full_i` high during the transfer raises `fifo_err_o`.
- R10: On a FIFO fault, the engine aborts. In the cycle in which `fifo_err_o` is high, `m_cyc_o` is low, no done pulse follows and no further word moves. A new command is accepted afterwards.
- R11: A command end that arrives while a transfer is in progress is ignored. The running transfer keeps its address and direction.
- R12: `tx_push_o` is never high while `tx_full_i` is high. The fetched word is held until space frees up.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the engine and the bus |
| rst | input | 1 | Synchronous active-high reset |
| cmd_end_i | input | 1 | One-cycle pulse: command stage finished |
| cmd_ok_i | input | 1 | Finished command had no error |
| cmd_data_i | input | 1 | Finished command carries a data payload |
| dir_wr_i | input | 1 | 1: memory to card, 0: card to memory |
| base_addr_i | input | ADDR_W | Shared start address register value |
| m_adr_o | output | ADDR_W | Bus address |
| m_dat_o | output | DATA_W | Bus write data |
| m_dat_i | input | DATA_W | Bus read data |
| m_sel_o | output | DATA_W/8 | Byte select, all ones |
| m_we_o | output | 1 | Bus write enable |
| m_cyc_o | output | 1 | Bus cycle |
| m_stb_o | output | 1 | Bus strobe |
| m_ack_i | input | 1 | Bus acknowledge |
| m_cti_o | output | 3 | Cycle type, always 000 |
| m_bte_o | output | 2 | Burst type, always 00 |
| tx_push_o | output | 1 | Push into transmit FIFO |
| tx_data_o | output | DATA_W | Transmit FIFO write data |
| tx_full_i | input | 1 | Transmit FIFO full |
| tx_empty_i | input | 1 | Transmit FIFO empty (drained by card side) |
| rx_pop_o | output | 1 | Pop from receive FIFO |
| rx_data_i | input | DATA_W | Receive FIFO head word |
| rx_empty_i | input | 1 | Receive FIFO empty |
| rx_full_i | input | 1 | Receive FIFO full |
| done_o | output | 1 | Block finished pulse |
| fifo_err_o | output | 1 | FIFO fault, transfer aborted |

## Verification
The to-card path is run with distinct word patterns at a fresh address. This separates correct address ordering and stepping from a stuck or mis-stepped address. The from-card path is run with memory wait states and a sentinel word past the block, which catches an off-by-one in the word count. Command ends are given with a failed status, without a payload, and in the middle of a running transfer, to show which of them are allowed to start the engine. A held full flag, a drained transmit FIFO and a filling receive FIFO separate plain backpressure, which must only stall, from the two fault cases, which must abort cleanly.

// File: rtl/blk_dma_pkg.sv
package blk_dma_pkg;
   typedef enum logic [2:0] {
      ST_IDLE,
      ST_FETCH,
      ST_PUSH,
      ST_POP,
      ST_STORE
   } dma_state_e;
endpackage

// File: rtl/blk_dma_addr_cnt.sv
module blk_dma_addr_cnt #(
   parameter int ADDR_W      = 32,
   parameter int STEP        = 4,
   parameter int BLOCK_WORDS = 128,
   parameter int CNT_W       = 8
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              load,
   input  logic [ADDR_W-1:0] base,
   input  logic              adr_step,
   input  logic              cnt_step,
   output logic [ADDR_W-1:0] addr,
   output logic              cnt_last,
   output logic              cnt_any
);
   localparam logic [CNT_W-1:0]  LAST_CNT = CNT_W'(BLOCK_WORDS - 1);
   localparam logic [ADDR_W-1:0] INC      = ADDR_W'(STEP);

   logic [CNT_W-1:0] count;

   always_ff @(posedge clk) begin
      if (rst) begin
         addr  <= '0;
         count <= '0;
      end else if (load) begin
         addr  <= base;
         count <= '0;
      end else begin
         if (adr_step) addr  <= addr + INC;
         if (cnt_step) count <= count + 1'b1;
      end
   end

   assign cnt_last = (count == LAST_CNT);
   assign cnt_any  = (count != '0);
endmodule

// File: rtl/blk_dma_fault.sv
module blk_dma_fault
   import blk_dma_pkg::*;
(
   input  dma_state_e state,
   input  logic       tx_empty,
   input  logic       rx_full,
   input  logic       cnt_any,
   output logic       fault
);
   always_comb begin
      unique case (state)
         ST_FETCH, ST_PUSH: fault = tx_empty && cnt_any;
         ST_POP, ST_STORE:  fault = rx_full;
         default:           fault = 1'b0;
      endcase
   end
endmodule

// File: rtl/blk_dma_fsm.sv
module blk_dma_fsm
   import blk_dma_pkg::*;
#(
   parameter int DATA_W = 32
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              go,
   input  logic              dir_wr,
   input  logic              ack,
   input  logic              fault,
   input  logic              cnt_last,
   input  logic              tx_full,
   input  logic              rx_empty,
   input  logic [DATA_W-1:0] bus_rdata,
   input  logic [DATA_W-1:0] rx_data,
   output dma_state_e        state,
   output logic              load,
   output logic              adr_step,
   output logic              cnt_step,
   output logic              tx_push,
   output logic              rx_pop,
   output logic [DATA_W-1:0] data_q,
   output logic              done,
   output logic              fifo_err
);
   dma_state_e state_n;
   logic       done_n, err_n, grab_bus, grab_rx;

   always_comb begin
      state_n  = state;
      load     = 1'b0;
      adr_step = 1'b0;
      cnt_step = 1'b0;
      tx_push  = 1'b0;
      rx_pop   = 1'b0;
      done_n   = 1'b0;
      err_n    = 1'b0;
      grab_bus = 1'b0;
      grab_rx  = 1'b0;
      unique case (state)
         ST_IDLE: if (go) begin
            load    = 1'b1;
            state_n = dir_wr ? ST_FETCH : ST_POP;
         end
         ST_FETCH: if (fault) begin
            err_n = 1'b1; state_n = ST_IDLE;
         end else if (ack) begin
            grab_bus = 1'b1; adr_step = 1'b1; state_n = ST_PUSH;
         end
         ST_PUSH: if (fault) begin
            err_n = 1'b1; state_n = ST_IDLE;
         end else if (!tx_full) begin
            tx_push  = 1'b1;
            cnt_step = 1'b1;
            if (cnt_last) begin done_n = 1'b1; state_n = ST_IDLE; end
            else state_n = ST_FETCH;
         end
         ST_POP: if (fault) begin
            err_n = 1'b1; state_n = ST_IDLE;
         end else if (!rx_empty) begin
            rx_pop = 1'b1; grab_rx = 1'b1; state_n = ST_STORE;
         end
         ST_STORE: if (fault) begin
            err_n = 1'b1; state_n = ST_IDLE;
         end else if (ack) begin
            adr_step = 1'b1;
            cnt_step = 1'b1;
            if (cnt_last) begin done_n = 1'b1; state_n = ST_IDLE; end
            else state_n = ST_POP;
         end
         default: state_n = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         state    <= ST_IDLE;
         data_q   <= '0;
         done     <= 1'b0;
         fifo_err <= 1'b0;
      end else begin
         state    <= state_n;
         done     <= done_n;
         fifo_err <= err_n;
         if (grab_bus)     data_q <= bus_rdata;
         else if (grab_rx) data_q <= rx_data;
      end
   end
endmodule

// File: rtl/blk_dma_master.sv
module blk_dma_master
   import blk_dma_pkg::*;
#(
   parameter int ADDR_W      = 32,
   parameter int DATA_W      = 32,
   parameter int BLOCK_WORDS = 128
) (
   input  logic                  clk,
   input  logic                  rst,
   input  logic                  cmd_end_i,
   input  logic                  cmd_ok_i,
   input  logic                  cmd_data_i,
   input  logic                  dir_wr_i,
   input  logic [ADDR_W-1:0]     base_addr_i,
   output logic [ADDR_W-1:0]     m_adr_o,
   output logic [DATA_W-1:0]     m_dat_o,
   input  logic [DATA_W-1:0]     m_dat_i,
   output logic [DATA_W/8-1:0]   m_sel_o,
   output logic                  m_we_o,
   output logic                  m_cyc_o,
   output logic                  m_stb_o,
   input  logic                  m_ack_i,
   output logic [2:0]            m_cti_o,
   output logic [1:0]            m_bte_o,
   output logic                  tx_push_o,
   output logic [DATA_W-1:0]     tx_data_o,
   input  logic                  tx_full_i,
   input  logic                  tx_empty_i,
   output logic                  rx_pop_o,
   input  logic [DATA_W-1:0]     rx_data_i,
   input  logic                  rx_empty_i,
   input  logic                  rx_full_i,
   output logic                  done_o,
   output logic                  fifo_err_o
);
   localparam int SEL_W = DATA_W / 8;
   localparam int STEP  = SEL_W;
   localparam int CNT_W = $clog2(BLOCK_WORDS) + 1;

   if (DATA_W % 8 != 0) begin : g_bad_width
      $error("DATA_W must be a whole number of bytes");
   end
   if (BLOCK_WORDS < 1) begin : g_bad_len
      $error("BLOCK_WORDS must be at least one");
   end
   if (ADDR_W < 3) begin : g_bad_addr
      $error("ADDR_W too narrow");
   end

   dma_state_e state;
   logic load, adr_step, cnt_step, cnt_last, cnt_any, fault, busy, go;
   logic [DATA_W-1:0] data_q;

   assign busy = (state != ST_IDLE);
   assign go   = cmd_end_i && cmd_ok_i && cmd_data_i && !busy;

   blk_dma_addr_cnt #(
      .ADDR_W(ADDR_W), .STEP(STEP), .BLOCK_WORDS(BLOCK_WORDS), .CNT_W(CNT_W)
   ) u_addr (
      .clk(clk), .rst(rst), .load(load), .base(base_addr_i),
      .adr_step(adr_step), .cnt_step(cnt_step), .addr(m_adr_o),
      .cnt_last(cnt_last), .cnt_any(cnt_any)
   );

   blk_dma_fault u_fault (
      .state(state), .tx_empty(tx_empty_i), .rx_full(rx_full_i),
      .cnt_any(cnt_any), .fault(fault)
   );

   blk_dma_fsm #(.DATA_W(DATA_W)) u_fsm (
      .clk(clk), .rst(rst), .go(go), .dir_wr(dir_wr_i), .ack(m_ack_i),
      .fault(fault), .cnt_last(cnt_last), .tx_full(tx_full_i),
      .rx_empty(rx_empty_i), .bus_rdata(m_dat_i), .rx_data(rx_data_i),
      .state(state), .load(load), .adr_step(adr_step), .cnt_step(cnt_step),
      .tx_push(tx_push_o), .rx_pop(rx_pop_o), .data_q(data_q),
      .done(done_o), .fifo_err(fifo_err_o)
   );

   assign m_cyc_o   = (state == ST_FETCH) || (state == ST_STORE);
   assign m_stb_o   = m_cyc_o;
   assign m_we_o    = (state == ST_STORE);
   assign m_dat_o   = data_q;
   assign tx_data_o = data_q;
   assign m_sel_o   = {SEL_W{1'b1}};
   assign m_cti_o   = 3'b000;
   assign m_bte_o   = 2'b00;
endmodule

// File: rtl/blk_dma_chk.sv
module blk_dma_chk #(
   parameter int ADDR_W = 32,
   parameter int STEP   = 4
) (
   input logic              clk,
   input logic              rst,
   input logic              busy,
   input logic              cmd_end_i,
   input logic              cmd_ok_i,
   input logic              cmd_data_i,
   input logic [ADDR_W-1:0] m_adr_o,
   input logic              m_cyc_o,
   input logic              m_stb_o,
   input logic              m_ack_i,
   input logic              tx_push_o,
   input logic              tx_full_i,
   input logic              done_o,
   input logic              fifo_err_o
);
   assert_no_bad_start_R1: assert property (@(posedge clk) disable iff (rst)
      (!busy && cmd_end_i && !(cmd_ok_i && cmd_data_i)) |=> !busy);

   assert_addr_step_R4: assert property (@(posedge clk) disable iff (rst)
      (m_cyc_o && m_ack_i) |=> (m_adr_o == $past(m_adr_o) + ADDR_W'(STEP)) || fifo_err_o);

   assert_hold_until_ack_R5: assert property (@(posedge clk) disable iff (rst)
      (m_cyc_o && m_stb_o && !m_ack_i) |=> (m_cyc_o && m_stb_o) || fifo_err_o);

   assert_gap_after_ack_R6: assert property (@(posedge clk) disable iff (rst)
      (m_cyc_o && m_ack_i) |=> !m_cyc_o);

   assert_done_single_R7: assert property (@(posedge clk) disable iff (rst)
      done_o |=> !done_o);

   assert_abort_idle_R10: assert property (@(posedge clk) disable iff (rst)
      fifo_err_o |-> (!m_cyc_o && !done_o));

   assert_no_push_full_R12: assert property (@(posedge clk) disable iff (rst)
      tx_push_o |-> !tx_full_i);
endmodule

bind blk_dma_master blk_dma_chk #(.ADDR_W(ADDR_W), .STEP(DATA_W/8)) u_chk (
   .clk(clk), .rst(rst), .busy(busy), .cmd_end_i(cmd_end_i),
   .cmd_ok_i(cmd_ok_i), .cmd_data_i(cmd_data_i), .m_adr_o(m_adr_o),
   .m_cyc_o(m_cyc_o), .m_stb_o(m_stb_o), .m_ack_i(m_ack_i),
   .tx_push_o(tx_push_o), .tx_full_i(tx_full_i), .done_o(done_o),
   .fifo_err_o(fifo_err_o)
);

// File: tb/blk_dma_master_tb.sv
module blk_dma_master_tb;
   localparam int CLK_PERIOD = 10;
   localparam int NW = 8;

   logic clk = 1'b0;
   logic rst = 1'b1;
   always #(CLK_PERIOD/2) clk = ~clk;

   logic        cmd_end = 0, cmd_ok = 0, cmd_data = 0, dir_wr = 0;
   logic [31:0] base = 0;
   logic [31:0] m_adr, m_dat_o, m_dat_i;
   logic [3:0]  m_sel;
   logic        m_we, m_cyc, m_stb;
   logic        ack_q;
   logic [2:0]  m_cti;
   logic [1:0]  m_bte;
   logic        tx_push, tx_full = 0, tx_empty = 0;
   logic [31:0] tx_data;
   logic        rx_pop, rx_empty, rx_full = 0;
   logic [31:0] rx_data;
   logic        done, ferr;

   blk_dma_master #(.ADDR_W(32), .DATA_W(32), .BLOCK_WORDS(NW)) u_dut (
      .clk(clk), .rst(rst), .cmd_end_i(cmd_end), .cmd_ok_i(cmd_ok),
      .cmd_data_i(cmd_data), .dir_wr_i(dir_wr), .base_addr_i(base),
      .m_adr_o(m_adr), .m_dat_o(m_dat_o), .m_dat_i(m_dat_i), .m_sel_o(m_sel),
      .m_we_o(m_we), .m_cyc_o(m_cyc), .m_stb_o(m_stb), .m_ack_i(ack_q),
      .m_cti_o(m_cti), .m_bte_o(m_bte), .tx_push_o(tx_push),
      .tx_data_o(tx_data), .tx_full_i(tx_full), .tx_empty_i(tx_empty),
      .rx_pop_o(rx_pop), .rx_data_i(rx_data), .rx_empty_i(rx_empty),
      .rx_full_i(rx_full), .done_o(done), .fifo_err_o(ferr)
   );

   // memory, FIFO models and event counters
   logic [31:0] mem [64];
   logic [31:0] tx_log [64];
   logic [31:0] adr_log [128];
   logic [31:0] rx_src [64];
   int ram_wait = 0, wcnt = 0;
   int push_cnt = 0, ack_cnt = 0, wr_cnt = 0, rx_head = 0, rx_avail = 0;
   int done_cnt = 0, err_cnt = 0, attr_bad = 0, err_cyc = 0;
   int tests = 0, fails = 0;

   assign m_dat_i  = mem[m_adr[7:2]];
   assign rx_empty = (rx_head >= rx_avail);
   assign rx_data  = rx_src[rx_head[5:0]];

   always @(posedge clk) begin
      if (rst) begin
         ack_q <= 1'b0; wcnt <= 0;
      end else if (m_cyc && m_stb && !ack_q) begin
         if (wcnt >= ram_wait) begin
            ack_q <= 1'b1; wcnt <= 0;
            if (m_we) begin mem[m_adr[7:2]] <= m_dat_o; wr_cnt <= wr_cnt + 1; end
         end else wcnt <= wcnt + 1;
      end else ack_q <= 1'b0;
      if (!rst) begin
         if (ack_q && m_cyc) begin adr_log[ack_cnt[6:0]] <= m_adr; ack_cnt <= ack_cnt + 1; end
         if (tx_push) begin tx_log[push_cnt[5:0]] <= tx_data; push_cnt <= push_cnt + 1; end
         if (rx_pop) rx_head <= rx_head + 1;
         if (done) done_cnt <= done_cnt + 1;
         if (ferr) err_cnt <= err_cnt + 1;
         if (ferr && m_cyc) err_cyc <= err_cyc + 1;
         if (m_cyc && (m_sel != 4'hF || m_cti != 3'd0 || m_bte != 2'd0)) attr_bad <= attr_bad + 1;
      end
   end

   task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
      tests++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
      end
   endtask

   task automatic cmd_pulse(input logic ok, input logic dat, input logic wr, input logic [31:0] a);
      @(negedge clk);
      cmd_end = 1; cmd_ok = ok; cmd_data = dat; dir_wr = wr; base = a;
      @(negedge clk);
      cmd_end = 0; cmd_ok = 0; cmd_data = 0;
   endtask

   task automatic wait_end(input int d0, input int e0);
      for (int i = 0; i < 600; i++) begin
         if (done_cnt != d0 || err_cnt != e0) break;
         @(negedge clk);
      end
      repeat (3) @(negedge clk);
   endtask

   task automatic t_reset;
      check(!m_cyc && !m_stb && !done && !ferr && !tx_push && !rx_pop, "reset", {28'd0, m_cyc, m_stb, done, ferr}, 0);
      check(m_cti == 3'd0 && m_bte == 2'd0 && m_sel == 4'hF, "R4 reset attributes", {23'd0, m_cti, m_bte, m_sel}, 32'h0000000F);
   endtask

   task automatic t_write_block;
      int p0 = push_cnt, a0 = ack_cnt, d0 = done_cnt, e0 = err_cnt;
      for (int i = 0; i < NW; i++) mem[16 + i] = 32'hA5C30000 + 32'(i * 17);
      cmd_pulse(1, 1, 1, 32'h40);
      wait_end(d0, e0);
      check(push_cnt - p0 == NW, "R2 push count", push_cnt - p0, NW);
      for (int i = 0; i < NW; i++)
         check(tx_log[p0 + i] == mem[16 + i], "R2 pushed word", tx_log[p0 + i], mem[16 + i]);
      for (int i = 0; i < NW; i++)
         check(adr_log[a0 + i] == 32'h40 + 32'(4 * i), "R4 address step", adr_log[a0 + i], 32'h40 + 32'(4 * i));
      check(done_cnt - d0 == 1, "R7 single done", done_cnt - d0, 1);
      check(attr_bad == 0, "R4 sel/cti/bte", attr_bad, 0);
   endtask

   task automatic t_bad_cmds;
      int a0 = ack_cnt, p0 = push_cnt, h0 = rx_head;
      cmd_pulse(0, 1, 1, 32'h40);
      cmd_pulse(1, 0, 1, 32'h40);
      cmd_pulse(0, 1, 0, 32'h80);
      repeat (20) begin
         @(negedge clk);
         if (m_cyc) a0 = -1000;
      end
      check(a0 >= 0 && ack_cnt == a0 && push_cnt == p0 && rx_head == h0, "R1 no start",
            ack_cnt + push_cnt + rx_head, a0 + p0 + h0);
   endtask

   task automatic t_read_block;
      int w0 = wr_cnt, d0 = done_cnt, e0 = err_cnt;
      mem[40] = 32'hDEADBEEF;
      for (int i = 0; i < NW; i++) rx_src[(rx_head + i) % 64] = 32'h5A000000 ^ 32'(i * 331);
      rx_avail = rx_head + NW;
      ram_wait = 2;
      cmd_pulse(1, 1, 0, 32'h80);
      wait_end(d0, e0);
      ram_wait = 0;
      check(wr_cnt - w0 == NW, "R3 store count", wr_cnt - w0, NW);
      for (int i = 0; i < NW; i++)
         check(mem[32 + i] == (32'h5A000000 ^ 32'(i * 331)), "R3 stored word", mem[32 + i], 32'h5A000000 ^ 32'(i * 331));
      check(mem[40] == 32'hDEADBEEF, "R3 sentinel", mem[40], 32'hDEADBEEF);
      check(done_cnt - d0 == 1, "R7 done after read", done_cnt - d0, 1);
   endtask

   task automatic t_backpressure;
      int p0 = push_cnt, d0 = done_cnt, e0 = err_cnt, held;
      for (int i = 0; i < NW; i++) mem[24 + i] = 32'h11110000 + 32'(i);
      cmd_pulse(1, 1, 1, 32'h60);
      while (push_cnt - p0 < 2) @(negedge clk);
      tx_full = 1;
      held = push_cnt;
      repeat (8) @(negedge clk);
      check(push_cnt == held, "R12 stall while full", push_cnt, held);
      tx_full = 0;
      wait_end(d0, e0);
      check(push_cnt - p0 == NW, "R12 all words after stall", push_cnt - p0, NW);
      check(tx_log[p0 + 2] == mem[26], "R12 held word", tx_log[p0 + 2], mem[26]);
   endtask

   task automatic t_busy_ignore;
      int p0 = push_cnt, d0 = done_cnt, e0 = err_cnt, h0 = rx_head;
      for (int i = 0; i < NW; i++) mem[48 + i] = 32'hC0DE0000 + 32'(i * 3);
      rx_avail = rx_head + 4;
      cmd_pulse(1, 1, 1, 32'hC0);
      repeat (3) @(negedge clk);
      cmd_pulse(1, 1, 0, 32'h00);
      wait_end(d0, e0);
      rx_avail = rx_head;
      check(rx_head == h0, "R11 no pops", rx_head, h0);
      check(tx_log[p0 + NW - 1] == mem[48 + NW - 1], "R11 kept address", tx_log[p0 + NW - 1], mem[48 + NW - 1]);
      check(done_cnt - d0 == 1, "R11 one done", done_cnt - d0, 1);
   endtask

   task automatic t_underrun;
      int p0 = push_cnt, d0 = done_cnt, e0 = err_cnt;
      cmd_pulse(1, 1, 1, 32'h40);
      while (push_cnt - p0 < 3) @(negedge clk);
      tx_empty = 1;
      repeat (20) @(negedge clk);
      tx_empty = 0;
      check(err_cnt - e0 == 1, "R8 fault pulse", err_cnt - e0, 1);
      check(push_cnt - p0 == 3, "R10 no more pushes", push_cnt - p0, 3);
      check(done_cnt == d0 && err_cyc == 0 && !m_cyc, "R10 clean abort", done_cnt - d0 + err_cyc, 0);
   endtask

   task automatic t_overrun;
      int w0 = wr_cnt, d0 = done_cnt, e0 = err_cnt;
      for (int i = 0; i < NW; i++) rx_src[(rx_head + i) % 64] = 32'(i);
      rx_avail = rx_head + NW;
      cmd_pulse(1, 1, 0, 32'h80);
      while (wr_cnt - w0 < 2) @(negedge clk);
      rx_full = 1;
      repeat (20) @(negedge clk);
      rx_full = 0;
      rx_avail = rx_head;
      check(err_cnt - e0 == 1, "R9 fault pulse", err_cnt - e0, 1);
      check(wr_cnt - w0 < NW && done_cnt == d0 && err_cyc == 0, "R10 abort on overrun", wr_cnt - w0, 2);
   endtask

   task automatic t_restart;
      int p0 = push_cnt, d0 = done_cnt, e0 = err_cnt;
      cmd_pulse(1, 1, 1, 32'h40);
      wait_end(d0, e0);
      check(push_cnt - p0 == NW && done_cnt - d0 == 1, "R10 restart after fault", push_cnt - p0, NW);
      check(tx_log[p0] == mem[16], "R2 restart first word", tx_log[p0], mem[16]);
   endtask

   initial begin
      for (int i = 0; i < 64; i++) begin mem[i] = 32'h0; rx_src[i] = 32'h0; end
      repeat (4) @(negedge clk);
      rst = 0;
      @(negedge clk);
      t_reset();
      t_write_block();
      t_bad_cmds();
      t_read_block();
      t_backpressure();
      t_busy_ignore();
      t_underrun();
      t_overrun();
      t_restart();
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      tests++;
      fails++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end
endmodule